// File: doc/BRIEF.md
# Sliding-Window MAP Decoder Schedule Generator

This block produces, cycle by cycle, the control stream that drives the four metric recursions of a sliding-window soft-in soft-out decoder. The block is a tailbiting block of `BLK_LEN` trellis steps, cut into windows of `WIN_LEN` steps. The four recursions are dummy forward, dummy backward, valid backward and valid forward. On each cycle the block gives each recursion an enable and a trellis position. It also gives the write and read addresses of the buffer that holds valid backward metrics between the two valid passes. The metric arithmetic is outside this block. `BLK_LEN` may also be set to one sub-block length when several decoders share a larger block.

After a one-cycle `start` pulse, the schedule runs for `BLK_LEN + 5*WIN_LEN` cycles. Each slot lasts one window length. Slot 0 warms up the forward metrics over the tail window, which is the last window of the block. Window w+1 gets its dummy backward pass in slot w+4. In the same slot, window w gets its valid backward pass, which writes into the buffer. Window w then gets its valid forward pass in slot w+5, which reads the buffer back. The last window has no following window to run a dummy pass over. Its backward start values are therefore the valid backward values captured at the end of window 0. This follows from the cyclic trellis. `done` pulses once the schedule ends.

Top module: `siso_window_sched`

## Requirements
- R1: After reset, and whenever no schedule is running, `busy`, `done` and all four enables are 0. A `start` pulse that arrives while `busy` is 1 has no effect on the schedule or on the time at which `done` appears.
- R2: In the first `WIN_LEN` cycles after `start`, only `df_en` is high. Over those cycles `df_pos` steps upward from `BLK_LEN-WIN_LEN` to `BLK_LEN-1`.
- R3: Dummy backward runs over windows 1 to K-1, where K = `BLK_LEN/WIN_LEN`. Window v runs in slot v+3 (slot s covers cycles s*WIN_LEN to s*WIN_LEN+WIN_LEN-1 after start). Positions run downward from v*WIN_LEN+WIN_LEN-1 to v*WIN_LEN.
- R4: Valid backward runs over windows 0 to K-1. Window w runs in slot w+4 with downward positions. `vb_first` marks its first cycle.
- R5: Valid forward runs over windows 0 to K-1. Window w runs in slot w+5 with upward positions w*WIN_LEN to w*WIN_LEN+WIN_LEN-1.
- R6: `bsave` is high only on the last cycle of window 0's valid backward pass, where position 0 is reached. `vb_from_save` is high only on the first cycle of window K-1's valid backward pass.
- R7: The buffer write address is {w mod 2, position mod WIN_LEN} while valid backward runs over window w, with `buf_we` high. The read address is {w mod 2, position mod WIN_LEN} while valid forward runs over window w, with `buf_re` high. The bank bit is the MSB. Each position is read back from the address where it was written, and a write and a read in the same cycle never use the same bank.
- R8: `done` is a single-cycle pulse in the cycle after the last `vf_en` cycle. It comes `BLK_LEN + 5*WIN_LEN` cycles after the first `df_en` cycle, and `busy` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one schedule when idle |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle end-of-schedule pulse |
| df_en | output | 1 | Dummy forward enable |
| df_pos | output | PW | Dummy forward trellis position |
| db_en | output | 1 | Dummy backward enable |
| db_pos | output | PW | Dummy backward trellis position |
| vb_en | output | 1 | Valid backward enable |
| vb_pos | output | PW | Valid backward trellis position |
| vb_first | output | 1 | First cycle of a valid backward window (load start values) |
| vb_from_save | output | 1 | Start values come from the saved register set |
| bsave | output | 1 | Capture valid backward values into the saved set |
| vf_en | output | 1 | Valid forward / output enable |
| vf_pos | output | PW | Valid forward trellis position |
| buf_we | output | 1 | Backward buffer write enable |
| buf_waddr | output | JW+1 | Backward buffer write address |
| buf_re | output | 1 | Backward buffer read enable |
| buf_raddr | output | JW+1 | Backward buffer read address |

## Verification
The bench targets the window seams. A design that mishandles them breaks the upward forward sequence or starts a dummy backward pass in the wrong slot. It also checks the tailbiting handoff: a save strobe in the wrong cycle, or a start-value select on any window other than the last, would load stale backward values. A shadow buffer model tracks every write and every read. It catches a bank bit that flips on the wrong window parity, or a reversed offset, which would hand the forward pass betas for the wrong position. A second `start` in mid-run, and a restart straight after `done`, test whether the run length shifts or the sequencer fails to return to idle.

// File: rtl/siso_window_sched.sv
module siso_window_sched #(
  parameter int BLK_LEN = 256,
  parameter int WIN_LEN = 32,
  localparam int NWIN = BLK_LEN / WIN_LEN,
  localparam int JW = $clog2(WIN_LEN),
  localparam int KW = $clog2(NWIN),
  localparam int PW = KW + JW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          df_en,
  output logic [PW-1:0] df_pos,
  output logic          db_en,
  output logic [PW-1:0] db_pos,
  output logic          vb_en,
  output logic [PW-1:0] vb_pos,
  output logic          vb_first,
  output logic          vb_from_save,
  output logic          bsave,
  output logic          vf_en,
  output logic [PW-1:0] vf_pos,
  output logic          buf_we,
  output logic [JW:0]   buf_waddr,
  output logic          buf_re,
  output logic [JW:0]   buf_raddr
);
  localparam int SLOTS = NWIN + 5;
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] S_WIN0 = SW'(4);
  localparam logic [SW-1:0] S_VF0  = SW'(5);
  localparam logic [SW-1:0] S_DBHI = SW'(NWIN + 2);
  localparam logic [SW-1:0] S_VBHI = SW'(NWIN + 3);
  localparam logic [SW-1:0] S_LAST = SW'(NWIN + 4);
  localparam logic [KW-1:0] W_LAST = KW'(NWIN - 1);

  initial begin
    assert (WIN_LEN == (1 << JW) && BLK_LEN == NWIN * WIN_LEN && NWIN >= 2)
      else $error("BLK_LEN must be a multiple (>=2) of a power-of-two WIN_LEN");
  end

  logic          run;
  logic [SW-1:0] slot;
  logic [JW-1:0] ofs;
  logic [JW-1:0] rev;
  logic [KW-1:0] db_w, vb_w, vf_w;
  logic          last_cyc;

  assign rev      = ~ofs;
  assign db_w     = KW'(slot - SW'(3));
  assign vb_w     = KW'(slot - SW'(4));
  assign vf_w     = KW'(slot - SW'(5));
  assign last_cyc = run && slot == S_LAST && ofs == '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      slot <= '0;
      ofs  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_cyc;
      if (!run) begin
        if (start) begin
          run  <= 1'b1;
          slot <= '0;
          ofs  <= '0;
        end
      end else begin
        ofs <= ofs + 1'b1;
        if (ofs == '1) begin
          if (slot == S_LAST) run  <= 1'b0;
          else                slot <= slot + 1'b1;
        end
      end
    end
  end

  assign busy   = run;

  assign df_en  = run && slot == '0;
  assign df_pos = {W_LAST, ofs};

  assign db_en  = run && slot >= S_WIN0 && slot <= S_DBHI;
  assign db_pos = {db_w, rev};

  assign vb_en        = run && slot >= S_WIN0 && slot <= S_VBHI;
  assign vb_pos       = {vb_w, rev};
  assign vb_first     = vb_en && ofs == '0;
  assign vb_from_save = vb_first && vb_w == W_LAST;
  assign bsave        = vb_en && vb_w == '0 && ofs == '1;

  assign vf_en  = run && slot >= S_VF0;
  assign vf_pos = {vf_w, ofs};

  assign buf_we    = vb_en;
  assign buf_waddr = {vb_w[0], rev};
  assign buf_re    = vf_en;
  assign buf_raddr = {vf_w[0], ofs};

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(df_en || db_en || vb_en || vf_en)); // R1
  AST_WARMUP_ALONE: assert property (@(posedge clk) disable iff (rst)
    df_en |-> !(db_en || vb_en || vf_en)); // R2
  AST_DUMMY_LEADS: assert property (@(posedge clk) disable iff (rst)
    (vb_first && !vb_from_save) |-> (db_en && db_pos == vb_pos + PW'(WIN_LEN))); // R3
  AST_VB_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (vb_en && !vb_first) |-> (vb_pos == $past(vb_pos) - PW'(1))); // R4
  AST_VF_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (vf_en && $past(vf_en)) |-> (vf_pos == $past(vf_pos) + PW'(1))); // R5
  AST_SAVE_BEFORE_USE: assert property (@(posedge clk) disable iff (rst)
    bsave |-> !vb_from_save); // R6
  AST_BANK_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (buf_we && buf_re) |-> (buf_waddr[JW] != buf_raddr[JW])); // R7
  AST_DONE_AFTER_VF: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(vf_en) && !vf_en && !busy)); // R8
endmodule

// File: tb/siso_window_sched_bench.sv
module siso_window_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WL = 32;
  localparam int N = 256;
  localparam int K = N / WL;
  localparam int JW = $clog2(WL);
  localparam int PW = $clog2(K) + JW;
  localparam int TOT = N + 5 * WL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, df_en, db_en, vb_en, vb_first, vb_from_save, bsave, vf_en, buf_we, buf_re;
  logic [PW-1:0] df_pos, db_pos, vb_pos, vf_pos;
  logic [JW:0] buf_waddr, buf_raddr;

  int checks = 0;
  int errors = 0;
  int shadow [2*WL];

  always #(CLK_PERIOD/2) clk = ~clk;

  siso_window_sched #(.BLK_LEN(N), .WIN_LEN(WL)) u_siso_window_sched (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .df_en(df_en), .df_pos(df_pos), .db_en(db_en), .db_pos(db_pos),
    .vb_en(vb_en), .vb_pos(vb_pos), .vb_first(vb_first), .vb_from_save(vb_from_save),
    .bsave(bsave), .vf_en(vf_en), .vf_pos(vf_pos),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_re(buf_re), .buf_raddr(buf_raddr));

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "busy", busy, 0);
    chk(req, "done", done, 0);
    chk(req, "enables", {df_en, db_en, vb_en, vf_en}, 0);
  endtask

  task automatic check_cycle(input int c);
    int s = c / WL;
    int j = c % WL;
    bit edf = (s == 0);
    bit edb = (s >= 4 && s <= K + 2);
    bit evb = (s >= 4 && s <= K + 3);
    bit evf = (s >= 5);
    chk("R8", "busy", busy, 1);
    chk("R8", "done", done, 0);
    chk("R2", "df_en", df_en, edf);
    if (edf) chk("R2", "df_pos", df_pos, (K - 1) * WL + j);
    chk("R3", "db_en", db_en, edb);
    if (edb) chk("R3", "db_pos", db_pos, (s - 3) * WL + WL - 1 - j);
    chk("R4", "vb_en", vb_en, evb);
    chk("R4", "vb_first", vb_first, evb && j == 0);
    if (evb) chk("R4", "vb_pos", vb_pos, (s - 4) * WL + WL - 1 - j);
    chk("R6", "bsave", bsave, s == 4 && j == WL - 1);
    chk("R6", "vb_from_save", vb_from_save, s == K + 3 && j == 0);
    chk("R5", "vf_en", vf_en, evf);
    if (evf) chk("R5", "vf_pos", vf_pos, (s - 5) * WL + j);
    chk("R7", "buf_we", buf_we, evb);
    chk("R7", "buf_re", buf_re, evf);
    if (evb) chk("R7", "buf_waddr", buf_waddr, ((s - 4) % 2) * WL + WL - 1 - j);
    if (evf) chk("R7", "buf_raddr", buf_raddr, ((s - 5) % 2) * WL + j);
    if (buf_re) chk("R7", "readback position", shadow[buf_raddr], vf_pos);
    if (buf_we) shadow[buf_waddr] = vb_pos;
  endtask

  task automatic run_schedule(input int extra_start_at);
    for (int a = 0; a < 2 * WL; a++) shadow[a] = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < TOT; c++) begin
      check_cycle(c);
      start = (c == extra_start_at);
      @(negedge clk);
      start = 1'b0;
    end
    chk("R8", "done pulse", done, 1);
    chk("R8", "busy at done", busy, 0);
    chk("R8", "vf_en at done", vf_en, 0);
    @(negedge clk);
    chk("R8", "done single cycle", done, 0);
    chk_quiet("R1");
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_quiet("R1");
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk_quiet("R1");
    end
  endtask

  task automatic t_full_run();
    run_schedule(-1);
  endtask

  task automatic t_start_while_busy();
    run_schedule(WL * 3 + 7);
    run_schedule(WL * (K + 4) + 2);
  endtask

  task automatic t_idle_then_back_to_back();
    repeat (5) begin
      @(negedge clk);
      chk_quiet("R1");
    end
    run_schedule(-1);
    run_schedule(-1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_full_run();
    t_start_while_busy();
    t_idle_then_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule